// File: doc/BRIEF.md
# Four-Channel Descriptor-Chain DMA Sequencer

This block drives four independent DMA channels, each of which walks a linked list of descriptors held in memory. A descriptor is fetched into the channel's working registers. The channel then gets one service slot out of every four. In each slot it hands a bounded burst (source, destination, length) to a downstream mover. When a descriptor's remaining count reaches zero, the channel may raise a completion interrupt, and in the same slot it fetches the descriptor named by its link. A null link stops the channel.

Software drives the block through a single-cycle command port. The commands are: append a descriptor to a channel, stop a channel, preload a channel's interrupt-suppression count, and preload a channel's fault-injection count. A command cycle takes the place of a service slot, so the scheduler never sees a channel half-updated. Descriptors are read through a wide port: the block presents one descriptor address and receives all of its fields in the same cycle. The only write the block ever makes to memory is the patch of a link word.

Top module: `sg_dma`

## Requirements
- R1: After reset, every channel is stopped, and no burst, interrupt, descriptor read or link write is presented.
- R2: Appending to a stopped channel reads the descriptor in the same cycle: `memRdEn` is high with `memRdAddr` equal to the appended address. The descriptor is loaded, the channel's link register takes the descriptor's next field, and the channel's `runMask` bit is set from the next cycle. A descriptor occupies five words at byte offsets 0 (source), 4 (destination), 8 (count), 12 (control) and 16 (next), and address 0 is the null link.
- R3: Slots visit channels 0, 1, 2, 3 in a repeating order, one channel per slot. A running channel with a nonzero count moves min(count, BURST) bytes in its slot, and its source and destination advance by the same amount. Bursts of one descriptor are therefore four slots apart.
- R4: A cycle carrying a command is not a service slot. No burst or interrupt follows it, and the slot order resumes where it stopped.
- R5: In the slot where a loaded descriptor's count is zero, the descriptor completes and the next one is fetched. The first burst of the next descriptor therefore comes eight slots after the last burst of the previous one.
- R6: A completing descriptor raises a one-cycle `cmplIrq` on its channel only when bit 0 of its control word is set.
- R7: When a descriptor completes and the channel's link register is null, the channel's run bit clears.
- R8: While its suppression count is nonzero, a channel that would raise a completion interrupt decrements the count instead. The count can be written only while the channel is stopped, and a write to a running channel has no effect.
- R9: A served slot with a nonzero fault count decrements that count. If the count was 1, the slot raises `errIrq`, clears run and moves no data; otherwise the slot proceeds normally. The fault count can be written only while the channel is stopped.
- R10: Appending to a running channel whose link register is null writes the appended address into the link register, with no memory read and no memory write.
- R11: Appending to a running channel whose link register is non-null writes the appended address to the next word of the previous last descriptor. In the same cycle, `linkWrEn` is high and `linkWrAddr` equals that descriptor's address plus 16.
- R12: A stop command clears the channel's run bit, and no further bursts are issued for that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 2 | 0 append, 1 stop, 2 set suppression count, 3 set fault count |
| cmdChan | input | 2 | Target channel |
| cmdAddr | input | 32 | Descriptor address being appended |
| cmdLast | input | 32 | Address of the current last descriptor of the chain |
| cmdArg | input | 8 | Count value for the two preload commands |
| memRdEn | output | 1 | Descriptor read request |
| memRdAddr | output | 32 | Descriptor base address |
| rdSrc | input | 32 | Source field of the addressed descriptor |
| rdDst | input | 32 | Destination field |
| rdCount | input | 16 | Byte count field |
| rdIntEn | input | 1 | Control word bit 0 |
| rdNext | input | 32 | Next-descriptor field |
| linkWrEn | output | 1 | Link word write request |
| linkWrAddr | output | 32 | Address of the link word |
| linkWrData | output | 32 | New link value |
| burstValid | output | 1 | Burst issued in the last slot |
| burstChan | output | 2 | Channel of the burst |
| burstSrc | output | 32 | Burst source address |
| burstDst | output | 32 | Burst destination address |
| burstLen | output | 16 | Burst length in bytes |
| runMask | output | 4 | Per-channel run state |
| cmplIrq | output | 4 | Per-channel completion pulse |
| errIrq | output | 4 | Per-channel fault pulse |

## Verification
A corrupted working register shows up within a single slot of that channel, at most four service slots later. It appears as a burst with the wrong address or length, or as one burst too many or too few before completion. A wrong link register or loaded flag surfaces at the next descriptor boundary. Either the following descriptor's bursts are missing or come from the wrong place, or the boundary spacing differs from eight slots. Faulty suppression or fault counters show as a wrong number of completion or error pulses over a chain. A scheduler that serves during command cycles or skips channels breaks the four-slot spacing seen at the burst port.

// File: rtl/sgdma_pkg.sv
`timescale 1ns/1ps
package sgdma_pkg;
  typedef enum logic [1:0] {
    OP_APPEND = 2'd0,
    OP_STOP   = 2'd1,
    OP_MISS   = 2'd2,
    OP_FAIL   = 2'd3
  } cmdOp_e;

  // strobes from control to datapath, applied to the selected channel
  typedef struct packed {
    logic load;
    logic burst;
    logic unload;
    logic runSet;
    logic runClr;
    logic nextWr;
    logic failWr;
    logic failDec;
    logic missWr;
    logic missDec;
  } dpStrobe_t;

  // byte offset of the link word inside a descriptor
  localparam int LINK_OFS = 16;
endpackage

// File: rtl/sgdma_datapath.sv
`timescale 1ns/1ps
module sgdma_datapath
  import sgdma_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int AW    = 32,
  parameter int CW    = 16,
  parameter int MW    = 8,
  parameter int BURST = 'h800,
  localparam int CHW  = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobe_t       stb,
  input  logic [CHW-1:0]  selCh,
  input  logic [AW-1:0]   rdSrc,
  input  logic [AW-1:0]   rdDst,
  input  logic [CW-1:0]   rdCount,
  input  logic            rdIntEn,
  input  logic [AW-1:0]   rdNext,
  input  logic [AW-1:0]   cmdAddr,
  input  logic [MW-1:0]   cmdArg,
  output logic [NCH-1:0]  runV,
  output logic [NCH-1:0]  loadedV,
  output logic [NCH-1:0]  cntZeroV,
  output logic [NCH-1:0]  intEnV,
  output logic [NCH-1:0]  failNzV,
  output logic [NCH-1:0]  failOneV,
  output logic [NCH-1:0]  missNzV,
  output logic [NCH-1:0]  nextNullV,
  output logic [AW-1:0]   nextSel,
  output logic            burstValid,
  output logic [CHW-1:0]  burstChan,
  output logic [AW-1:0]   burstSrc,
  output logic [AW-1:0]   burstDst,
  output logic [CW-1:0]   burstLen
);
  logic [AW-1:0] srcR  [NCH];
  logic [AW-1:0] dstR  [NCH];
  logic [AW-1:0] nextR [NCH];
  logic [CW-1:0] cntR  [NCH];
  logic [MW-1:0] failR [NCH];
  logic [MW-1:0] missR [NCH];
  logic [NCH-1:0] intR, loadedR, runR;

  logic [CW-1:0] cntSel, lenSel;
  assign cntSel  = cntR[selCh];
  assign lenSel  = (cntSel > CW'(BURST)) ? CW'(BURST) : cntSel;
  assign nextSel = nextR[selCh];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NCH; i++) begin
        srcR[i]  <= '0;
        dstR[i]  <= '0;
        nextR[i] <= '0;
        cntR[i]  <= '0;
        failR[i] <= '0;
        missR[i] <= '0;
      end
      intR       <= '0;
      loadedR    <= '0;
      runR       <= '0;
      burstValid <= 1'b0;
      burstChan  <= '0;
      burstSrc   <= '0;
      burstDst   <= '0;
      burstLen   <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (selCh == CHW'(i)) begin
          if (stb.load) begin
            srcR[i]    <= rdSrc;
            dstR[i]    <= rdDst;
            cntR[i]    <= rdCount;
            intR[i]    <= rdIntEn;
            nextR[i]   <= rdNext;
            loadedR[i] <= 1'b1;
          end else begin
            if (stb.burst) begin
              cntR[i] <= cntR[i] - lenSel;
              srcR[i] <= srcR[i] + AW'(lenSel);
              dstR[i] <= dstR[i] + AW'(lenSel);
            end
            if (stb.unload) loadedR[i] <= 1'b0;
            if (stb.nextWr) nextR[i] <= cmdAddr;
          end
          if (stb.runSet)      runR[i] <= 1'b1;
          else if (stb.runClr) runR[i] <= 1'b0;
          if (stb.failWr)       failR[i] <= cmdArg;
          else if (stb.failDec) failR[i] <= failR[i] - 1'b1;
          if (stb.missWr)       missR[i] <= cmdArg;
          else if (stb.missDec) missR[i] <= missR[i] - 1'b1;
        end
      end
      burstValid <= stb.burst;
      burstChan  <= selCh;
      burstSrc   <= srcR[selCh];
      burstDst   <= dstR[selCh];
      burstLen   <= lenSel;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : gStat
    assign runV[g]      = runR[g];
    assign loadedV[g]   = loadedR[g];
    assign cntZeroV[g]  = (cntR[g] == '0);
    assign intEnV[g]    = intR[g];
    assign failNzV[g]   = (failR[g] != '0);
    assign failOneV[g]  = (failR[g] == MW'(1));
    assign missNzV[g]   = (missR[g] != '0);
    assign nextNullV[g] = (nextR[g] == '0);
  end
endmodule

// File: rtl/sgdma_ctrl.sv
`timescale 1ns/1ps
module sgdma_ctrl
  import sgdma_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int AW   = 32,
  localparam int CHW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [1:0]      cmdOp,
  input  logic [CHW-1:0]  cmdChan,
  input  logic [AW-1:0]   cmdAddr,
  input  logic [AW-1:0]   cmdLast,
  input  logic [NCH-1:0]  runV,
  input  logic [NCH-1:0]  loadedV,
  input  logic [NCH-1:0]  cntZeroV,
  input  logic [NCH-1:0]  intEnV,
  input  logic [NCH-1:0]  failNzV,
  input  logic [NCH-1:0]  failOneV,
  input  logic [NCH-1:0]  missNzV,
  input  logic [NCH-1:0]  nextNullV,
  input  logic [AW-1:0]   nextSel,
  output dpStrobe_t       stb,
  output logic [CHW-1:0]  selCh,
  output logic            memRdEn,
  output logic [AW-1:0]   memRdAddr,
  output logic            linkWrEn,
  output logic [AW-1:0]   linkWrAddr,
  output logic [AW-1:0]   linkWrData,
  output logic [NCH-1:0]  cmplIrq,
  output logic [NCH-1:0]  errIrq
);
  logic [CHW-1:0] ptr;
  logic [NCH-1:0] cmplNext, errNext;

  always_comb begin
    stb        = '0;
    memRdEn    = 1'b0;
    memRdAddr  = '0;
    linkWrEn   = 1'b0;
    linkWrAddr = '0;
    linkWrData = '0;
    cmplNext   = '0;
    errNext    = '0;
    selCh      = cmdValid ? cmdChan : ptr;
    if (cmdValid) begin
      case (cmdOp_e'(cmdOp))
        OP_APPEND: begin
          if (!runV[cmdChan]) begin
            memRdEn    = 1'b1;
            memRdAddr  = cmdAddr;
            stb.load   = 1'b1;
            stb.runSet = 1'b1;
          end else if (nextNullV[cmdChan]) begin
            stb.nextWr = 1'b1;
          end else begin
            linkWrEn   = 1'b1;
            linkWrAddr = cmdLast + AW'(LINK_OFS);
            linkWrData = cmdAddr;
          end
        end
        OP_STOP: stb.runClr = 1'b1;
        OP_MISS: stb.missWr = !runV[cmdChan];
        OP_FAIL: stb.failWr = !runV[cmdChan];
        default: ;
      endcase
    end else if (runV[ptr]) begin
      if (failNzV[ptr]) stb.failDec = 1'b1;
      if (failOneV[ptr]) begin
        stb.runClr   = 1'b1;
        errNext[ptr] = 1'b1;
      end else if (loadedV[ptr] && !cntZeroV[ptr]) begin
        stb.burst = 1'b1;
      end else begin
        if (loadedV[ptr]) begin
          stb.unload = 1'b1;
          if (intEnV[ptr]) begin
            if (missNzV[ptr]) stb.missDec = 1'b1;
            else              cmplNext[ptr] = 1'b1;
          end
        end
        if (!nextNullV[ptr]) begin
          memRdEn   = 1'b1;
          memRdAddr = nextSel;
          stb.load  = 1'b1;
        end else begin
          stb.runClr = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr     <= '0;
      cmplIrq <= '0;
      errIrq  <= '0;
    end else begin
      if (!cmdValid) ptr <= (ptr == CHW'(NCH - 1)) ? '0 : ptr + 1'b1;
      cmplIrq <= cmplNext;
      errIrq  <= errNext;
    end
  end
endmodule

// File: rtl/sg_dma.sv
`timescale 1ns/1ps
module sg_dma
  import sgdma_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int AW    = 32,
  parameter int CW    = 16,
  parameter int MW    = 8,
  parameter int BURST = 'h800,
  localparam int CHW  = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [1:0]      cmdOp,
  input  logic [CHW-1:0]  cmdChan,
  input  logic [AW-1:0]   cmdAddr,
  input  logic [AW-1:0]   cmdLast,
  input  logic [MW-1:0]   cmdArg,
  output logic            memRdEn,
  output logic [AW-1:0]   memRdAddr,
  input  logic [AW-1:0]   rdSrc,
  input  logic [AW-1:0]   rdDst,
  input  logic [CW-1:0]   rdCount,
  input  logic            rdIntEn,
  input  logic [AW-1:0]   rdNext,
  output logic            linkWrEn,
  output logic [AW-1:0]   linkWrAddr,
  output logic [AW-1:0]   linkWrData,
  output logic            burstValid,
  output logic [CHW-1:0]  burstChan,
  output logic [AW-1:0]   burstSrc,
  output logic [AW-1:0]   burstDst,
  output logic [CW-1:0]   burstLen,
  output logic [NCH-1:0]  runMask,
  output logic [NCH-1:0]  cmplIrq,
  output logic [NCH-1:0]  errIrq
);
  dpStrobe_t      stb;
  logic [CHW-1:0] selCh;
  logic [NCH-1:0] runV, loadedV, cntZeroV, intEnV, failNzV, failOneV, missNzV, nextNullV;
  logic [AW-1:0]  nextSel;

  sgdma_ctrl #(.NCH(NCH), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdChan(cmdChan),
    .cmdAddr(cmdAddr), .cmdLast(cmdLast), .runV(runV), .loadedV(loadedV),
    .cntZeroV(cntZeroV), .intEnV(intEnV), .failNzV(failNzV), .failOneV(failOneV),
    .missNzV(missNzV), .nextNullV(nextNullV), .nextSel(nextSel), .stb(stb),
    .selCh(selCh), .memRdEn(memRdEn), .memRdAddr(memRdAddr), .linkWrEn(linkWrEn),
    .linkWrAddr(linkWrAddr), .linkWrData(linkWrData), .cmplIrq(cmplIrq), .errIrq(errIrq)
  );

  sgdma_datapath #(.NCH(NCH), .AW(AW), .CW(CW), .MW(MW), .BURST(BURST)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .selCh(selCh), .rdSrc(rdSrc), .rdDst(rdDst),
    .rdCount(rdCount), .rdIntEn(rdIntEn), .rdNext(rdNext), .cmdAddr(cmdAddr),
    .cmdArg(cmdArg), .runV(runV), .loadedV(loadedV), .cntZeroV(cntZeroV),
    .intEnV(intEnV), .failNzV(failNzV), .failOneV(failOneV), .missNzV(missNzV),
    .nextNullV(nextNullV), .nextSel(nextSel), .burstValid(burstValid),
    .burstChan(burstChan), .burstSrc(burstSrc), .burstDst(burstDst), .burstLen(burstLen)
  );

  assign runMask = runV;
endmodule

// File: rtl/sgdma_chk.sv
`timescale 1ns/1ps
module sgdma_chk #(
  parameter int NCH   = 4,
  parameter int CW    = 16,
  parameter int BURST = 'h800,
  localparam int CHW  = $clog2(NCH)
) (
  input logic           clk,
  input logic           rstN,
  input logic           cmdValid,
  input logic           memRdEn,
  input logic           linkWrEn,
  input logic           burstValid,
  input logic [CHW-1:0] burstChan,
  input logic [CW-1:0]  burstLen,
  input logic [NCH-1:0] runMask,
  input logic [NCH-1:0] cmplIrq,
  input logic [NCH-1:0] errIrq
);
  AST_CMD_NO_BURST: assert property (@(posedge clk) disable iff (!rstN) cmdValid |=> !burstValid); // R4
  AST_CMD_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN) cmdValid |=> (cmplIrq == '0 && errIrq == '0)); // R4
  AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rstN) burstValid |-> (burstLen != '0 && burstLen <= CW'(BURST))); // R3
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rstN) $countones({cmplIrq, errIrq}) <= 1); // R3
  AST_BURST_RUNNING: assert property (@(posedge clk) disable iff (!rstN) burstValid |-> runMask[burstChan]); // R3
  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rstN) (errIrq != '0) |-> ((errIrq & runMask) == '0)); // R9
  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(memRdEn && linkWrEn)); // R11
endmodule

bind sg_dma sgdma_chk #(.NCH(NCH), .CW(CW), .BURST(BURST)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .memRdEn(memRdEn), .linkWrEn(linkWrEn),
  .burstValid(burstValid), .burstChan(burstChan), .burstLen(burstLen),
  .runMask(runMask), .cmplIrq(cmplIrq), .errIrq(errIrq)
);

// File: tb/sg_dma_tb.sv
`timescale 1ns/1ps
module sg_dma_tb;
  localparam int NCH = 4, AW = 32, CW = 16, MW = 8, BURST = 'h800;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, cmdValid;
  logic [1:0] cmdOp, cmdChan, burstChan;
  logic [AW-1:0] cmdAddr, cmdLast, memRdAddr, rdSrc, rdDst, rdNext, linkWrAddr, linkWrData, burstSrc, burstDst;
  logic [MW-1:0] cmdArg;
  logic [CW-1:0] rdCount, burstLen;
  logic memRdEn, rdIntEn, linkWrEn, burstValid;
  logic [NCH-1:0] runMask, cmplIrq, errIrq;

  logic [AW-1:0] mSrc [16];
  logic [AW-1:0] mDst [16];
  logic [AW-1:0] mNext [16];
  logic [CW-1:0] mCnt [16];
  logic          mInt [16];
  assign rdSrc   = mSrc[memRdAddr[11:8]];
  assign rdDst   = mDst[memRdAddr[11:8]];
  assign rdCount = mCnt[memRdAddr[11:8]];
  assign rdIntEn = mInt[memRdAddr[11:8]];
  assign rdNext  = mNext[memRdAddr[11:8]];

  sg_dma u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdChan(cmdChan),
    .cmdAddr(cmdAddr), .cmdLast(cmdLast), .cmdArg(cmdArg), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .rdSrc(rdSrc), .rdDst(rdDst), .rdCount(rdCount),
    .rdIntEn(rdIntEn), .rdNext(rdNext), .linkWrEn(linkWrEn), .linkWrAddr(linkWrAddr),
    .linkWrData(linkWrData), .burstValid(burstValid), .burstChan(burstChan),
    .burstSrc(burstSrc), .burstDst(burstDst), .burstLen(burstLen), .runMask(runMask),
    .cmplIrq(cmplIrq), .errIrq(errIrq)
  );

  typedef struct {
    logic [AW-1:0] src;
    logic [AW-1:0] dst;
    int len;
    int gap;
  } exp_t;

  exp_t expQ [4][$];
  int checks = 0, errors = 0;
  int cmplCnt [4], errCnt [4], ignCnt [4], lastSlot [4];
  bit ign [4];
  int slotCnt;
  logic smpRd, smpWr;
  logic [AW-1:0] smpRdAddr, smpWrAddr, smpWrData;

  always @(posedge clk) begin
    if (!rstN) slotCnt <= 0;
    else if (!cmdValid) slotCnt <= slotCnt + 1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic monitor();
    forever begin
      @(negedge clk);
      if (rstN) begin
        for (int i = 0; i < 4; i++) begin
          cmplCnt[i] += int'(cmplIrq[i]);
          errCnt[i]  += int'(errIrq[i]);
        end
        if (burstValid) begin
          int c;
          exp_t e;
          c = int'(burstChan);
          if (ign[c]) ignCnt[c]++;
          else if (expQ[c].size() == 0) chk(1'b0, "R3 unexpected burst on channel", c, -1);
          else begin
            e = expQ[c].pop_front();
            chk(burstSrc == e.src, "R3 burst source", burstSrc, e.src);
            chk(burstDst == e.dst, "R3 burst destination", burstDst, e.dst);
            chk(int'(burstLen) == e.len, "R3 burst length", burstLen, e.len);
            if (e.gap != 0)
              chk(slotCnt - lastSlot[c] == e.gap, (e.gap == 8) ? "R5 boundary spacing" : "R3 slot spacing",
                  slotCnt - lastSlot[c], e.gap);
          end
          lastSlot[c] = slotCnt;
        end
      end
    end
  endtask

  task automatic watchdog();
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic setDesc(input int idx, input logic [AW-1:0] s, input logic [AW-1:0] d,
                         input int cnt, input bit ie, input logic [AW-1:0] nx);
    mSrc[idx] = s; mDst[idx] = d; mCnt[idx] = CW'(cnt); mInt[idx] = ie; mNext[idx] = nx;
  endtask

  task automatic addDesc(input int ch, input int idx, input logic [AW-1:0] s, input logic [AW-1:0] d,
                         input int cnt, input bit ie, input logic [AW-1:0] nx, input bit chained);
    int rem;
    int len;
    bit first;
    exp_t e;
    setDesc(idx, s, d, cnt, ie, nx);
    rem = cnt;
    first = 1'b1;
    while (rem > 0) begin
      len = (rem > BURST) ? BURST : rem;
      e.src = s; e.dst = d; e.len = len;
      e.gap = first ? (chained ? 8 : 0) : 4;
      expQ[ch].push_back(e);
      s += AW'(len); d += AW'(len); rem -= len; first = 1'b0;
    end
  endtask

  task automatic cmd(input int op, input int ch, input logic [AW-1:0] a, input logic [AW-1:0] last, input int arg);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'(op); cmdChan = 2'(ch); cmdAddr = a; cmdLast = last; cmdArg = MW'(arg);
    #1;
    smpRd = memRdEn; smpRdAddr = memRdAddr; smpWr = linkWrEn; smpWrAddr = linkWrAddr; smpWrData = linkWrData;
    if (smpWr) mNext[((smpWrAddr - 32'd16) >> 8) & 32'hF] = smpWrData;
    @(negedge clk);
    cmdValid = 1'b0;
    #1;
    chk(!burstValid && cmplIrq == '0 && errIrq == '0, "R4 command cycle serves no slot", burstValid, 0);
  endtask

  task automatic waitIdle(input string tag);
    int n;
    n = 0;
    while (runMask != '0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    #1;
    chk(runMask == '0, tag, runMask, 0);
  endtask

  initial begin
    int b0, b1;
    int n;
    rstN = 1'b0; cmdValid = 1'b0; cmdOp = '0; cmdChan = '0; cmdAddr = '0; cmdLast = '0; cmdArg = '0;
    for (int i = 0; i < 16; i++) setDesc(i, '0, '0, 0, 1'b0, '0);
    for (int i = 0; i < 4; i++) begin
      cmplCnt[i] = 0; errCnt[i] = 0; ignCnt[i] = 0; lastSlot[i] = 0; ign[i] = 1'b0;
    end
    fork
      monitor();
      watchdog();
    join_none
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(runMask == '0, "R1 run mask after reset", runMask, 0);
    chk(!burstValid && cmplIrq == '0 && errIrq == '0, "R1 no burst or irq after reset", burstValid, 0);
    chk(!memRdEn && !linkWrEn, "R1 no memory access after reset", memRdEn, 0);

    // single descriptor split into bursts, R2 and R7
    addDesc(0, 1, 32'h1000, 32'h8000, 'h1810, 1'b1, 0, 1'b0);
    b0 = cmplCnt[0];
    cmd(0, 0, 32'h100, 0, 0);
    chk(smpRd && smpRdAddr == 32'h100, "R2 fetch address on start", smpRdAddr, 32'h100);
    chk(runMask[0], "R2 run set after start", runMask, 1);
    waitIdle("R7 run clears at null link");
    chk(expQ[0].size() == 0, "R3 all bursts of single descriptor", expQ[0].size(), 0);
    chk(cmplCnt[0] - b0 == 1, "R6 completion with bit 0 set", cmplCnt[0] - b0, 1);

    // three-descriptor chain, only last requests an interrupt (R5, R6)
    addDesc(1, 2, 32'h2000, 32'h9000, 'h900, 1'b0, 32'h300, 1'b0);
    addDesc(1, 3, 32'h3000, 32'hA000, 'h10, 1'b0, 32'h400, 1'b1);
    addDesc(1, 4, 32'h4000, 32'hB000, 'h800, 1'b1, 0, 1'b1);
    b0 = cmplCnt[1];
    cmd(0, 1, 32'h200, 0, 0);
    waitIdle("R7 chain ends");
    chk(expQ[1].size() == 0, "R5 chain bursts", expQ[1].size(), 0);
    chk(cmplCnt[1] - b0 == 1, "R6 bit 0 clear gives no irq", cmplCnt[1] - b0, 1);

    // zero-count descriptor completes and fetches next
    setDesc(5, 32'h5000, 32'h5000, 0, 1'b1, 32'h600);
    addDesc(2, 6, 32'h6000, 32'hC000, 'h20, 1'b0, 0, 1'b0);
    b0 = cmplCnt[2];
    cmd(0, 2, 32'h500, 0, 0);
    waitIdle("R7 zero count chain ends");
    chk(expQ[2].size() == 0, "R5 descriptor after zero count", expQ[2].size(), 0);
    chk(cmplCnt[2] - b0 == 1, "R6 zero count completion irq", cmplCnt[2] - b0, 1);

    // suppression counter R8
    cmd(2, 3, 0, 0, 2);
    addDesc(3, 7, 32'h7000, 32'hD000, 'h10, 1'b1, 32'h800, 1'b0);
    addDesc(3, 8, 32'h7100, 32'hD100, 'h10, 1'b1, 32'h900, 1'b1);
    addDesc(3, 9, 32'h7200, 32'hD200, 'h10, 1'b1, 0, 1'b1);
    b0 = cmplCnt[3];
    cmd(0, 3, 32'h700, 0, 0);
    waitIdle("R7 suppressed chain ends");
    chk(cmplCnt[3] - b0 == 1, "R8 two of three interrupts suppressed", cmplCnt[3] - b0, 1);
    addDesc(3, 10, 32'h20000, 32'h30000, 'h1000, 1'b1, 0, 1'b0);
    b0 = cmplCnt[3];
    cmd(0, 3, 32'hA00, 0, 0);
    cmd(2, 3, 0, 0, 3);
    waitIdle("R7 after ignored write");
    chk(cmplCnt[3] - b0 == 1, "R8 write while running ignored", cmplCnt[3] - b0, 1);
    chk(expQ[3].size() == 0, "R3 bursts with suppression", expQ[3].size(), 0);

    // fault counter R9
    setDesc(11, 32'hB000, 32'hD000, 'h10, 1'b1, 0);
    b0 = cmplCnt[3]; b1 = errCnt[3];
    cmd(3, 3, 0, 0, 1);
    cmd(0, 3, 32'hB00, 0, 0);
    waitIdle("R9 fault stops channel");
    chk(errCnt[3] - b1 == 1, "R9 error pulse count 1", errCnt[3] - b1, 1);
    chk(cmplCnt[3] - b0 == 0, "R9 no completion on fault", cmplCnt[3] - b0, 0);
    setDesc(11, 32'hB000, 32'hD000, 'h1000, 1'b1, 0);
    begin
      exp_t e;
      e.src = 32'hB000; e.dst = 32'hD000; e.len = 'h800; e.gap = 0;
      expQ[3].push_back(e);
    end
    b0 = cmplCnt[3]; b1 = errCnt[3];
    cmd(3, 3, 0, 0, 2);
    cmd(0, 3, 32'hB00, 0, 0);
    waitIdle("R9 fault count 2 stops channel");
    chk(errCnt[3] - b1 == 1, "R9 error after one burst", errCnt[3] - b1, 1);
    chk(expQ[3].size() == 0 && cmplCnt[3] == b0, "R9 exactly one burst before fault", expQ[3].size(), 0);

    // append cases R10, R11
    addDesc(0, 12, 32'h40000, 32'h50000, 'h1000, 1'b1, 0, 1'b0);
    addDesc(0, 13, 32'h41000, 32'h51000, 'h10, 1'b1, 0, 1'b1);
    addDesc(0, 14, 32'h42000, 32'h52000, 'h10, 1'b1, 0, 1'b1);
    b0 = cmplCnt[0];
    cmd(0, 0, 32'hC00, 0, 0);
    cmd(0, 0, 32'hD00, 32'hC00, 0);
    chk(!smpRd && !smpWr, "R10 append to null link touches no memory", {smpRd, smpWr}, 0);
    cmd(0, 0, 32'hE00, 32'hD00, 0);
    chk(smpWr && smpWrAddr == 32'hD10, "R11 link write address", smpWrAddr, 32'hD10);
    chk(smpWrData == 32'hE00 && !smpRd, "R11 link write data", smpWrData, 32'hE00);
    waitIdle("R7 appended chain ends");
    chk(expQ[0].size() == 0, "R10 appended descriptors all run", expQ[0].size(), 0);
    chk(cmplCnt[0] - b0 == 3, "R11 three completions", cmplCnt[0] - b0, 3);

    // stop R12
    ign[1] = 1'b1;
    setDesc(15, 32'h0, 32'h0, 'hFFFF, 1'b0, 0);
    cmd(0, 1, 32'hF00, 0, 0);
    repeat (20) @(negedge clk);
    #1;
    chk(runMask[1], "R12 running before stop", runMask, 2);
    cmd(1, 1, 0, 0, 0);
    chk(!runMask[1], "R12 run cleared by stop", runMask, 0);
    n = ignCnt[1];
    repeat (40) @(negedge clk);
    #1;
    chk(ignCnt[1] == n && n > 0, "R12 no bursts after stop", ignCnt[1], n);
    ign[1] = 1'b0;

    // all four channels in rotation R3
    for (int c = 0; c < 4; c++)
      addDesc(c, 1 + c, 32'h10000 * (c + 1), 32'h80000 + 32'h10000 * c, 'h1800, 1'b1, 0, 1'b0);
    b0 = cmplCnt[0] + cmplCnt[1] + cmplCnt[2] + cmplCnt[3];
    for (int c = 0; c < 4; c++) cmd(0, c, 32'h100 * (1 + c), 0, 0);
    waitIdle("R7 four channels finish");
    for (int c = 0; c < 4; c++)
      chk(expQ[c].size() == 0, "R3 rotation bursts per channel", expQ[c].size(), 0);
    chk(cmplCnt[0] + cmplCnt[1] + cmplCnt[2] + cmplCnt[3] - b0 == 4, "R6 one completion per channel",
        cmplCnt[0] + cmplCnt[1] + cmplCnt[2] + cmplCnt[3] - b0, 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule